// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer with Early Device Stop

This block runs the operand transfers of a single DMA channel and decides when the channel stops. It works in one of two addressing modes. In dual-address mode each operand is a read at the source pointer followed by a write at the destination pointer. In single-address mode each operand is one memory access, and the peripheral is addressed implicitly. The bus side is one request per access. The access completes on a cycle where the ready input is high, so a slow responder inserts wait states simply by holding ready low.

A transfer normally ends when the byte count reaches zero. A peripheral can end it early by raising a done input while it is being accessed. When that input is looked at depends on the mode:
- A done on a device-read phase still lets the paired write complete.
- A done on a device-write or single-address access stops the channel after that access.
- A done on a device-read phase is looked at one clock after the read completes.
- With the synchronizer in use, done must be presented one clock ahead of the sample point.

Clearing the run bit parks the channel at the next operand boundary with pointers and count intact. Setting the run bit again continues from where it stopped.

Top module: `dma_term_ctl`

## Requirements
- R1: After reset the run bit, the interrupt flag, both pointers and the count are zero, and no bus access is requested.
- R2: In dual mode (dualMode=1) each operand is one read (busWrite=0) at srcPtr, then one write (busWrite=1) at dstPtr. Each access holds its request and address until a cycle with busRdy=1. One idle cycle separates operands.
- R3: In single mode (dualMode=0) each operand is one access. With devIsDst=1 it reads memory at srcPtr. With devIsDst=0 it writes memory at dstPtr. Only that pointer advances.
- R4: Each completed access advances its pointer by the operand size: opSize 0 is 1 byte, 1 is 2 bytes, 2 or 3 is 4 bytes. Each completed operand lowers the count by the same amount, stopping at zero if less remains.
- R5: When an operand brings the count to zero, the channel stops after that operand.
- R6: With devIsDst=1, done is sampled on the clock that completes the write (dual) or the access (single). If it is seen there, no further access is issued.
- R7: In dual mode with devIsDst=0, done is sampled on the first clock of the write phase, one clock after the read completes. If it is seen there, the write still completes and the channel then stops.
- R8: With syncBypass=1, done is taken from the input on the sample clock. With syncBypass=0, it is taken from the input one clock earlier.
- R9: On any stop the run bit clears and the interrupt flag sets. doneIrq equals the flag ANDed with intMask.
- R10: The interrupt flag holds until intClr is high on a clock; a stop on the same clock wins. Starting a new transfer does not clear it.
- R11: Starting with a count of zero stops the channel at once and sets the flag, with no bus access.
- R12: Clearing the run bit (startClr) lets the current operand finish and then issues nothing more, keeping pointers and count. startSet resumes from them. If both are high on one clock, startClr wins.
- R13: A register write (wrSel 0 = source, 1 = destination, 2 = count, 3 = none) takes effect only while the run bit is clear and no operand is in progress. Otherwise it is ignored.
- R14: devAck is high on every clock of a device access: every single-mode access, the read phase when devIsDst=0, and the write phase when devIsDst=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startSet | input | 1 | Set the run bit |
| startClr | input | 1 | Clear the run bit (suspend) |
| dualMode | input | 1 | 1 = dual-address, 0 = single-address |
| devIsDst | input | 1 | 1 = peripheral is the destination, 0 = source |
| syncBypass | input | 1 | 1 = use done without the synchronizer |
| opSize | input | 2 | Operand size code |
| intMask | input | 1 | Interrupt enable |
| intClr | input | 1 | Clear the interrupt flag |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select for the write |
| wrData | input | ADDR_W | Write data |
| busRdy | input | 1 | Current access completes this clock |
| extDone | input | 1 | Peripheral done request |
| busReq | output | 1 | Access requested |
| busWrite | output | 1 | Access direction, 1 = write |
| busAddr | output | ADDR_W | Access address, zero when idle |
| devAck | output | 1 | Peripheral is being accessed |
| active | output | 1 | Run bit |
| doneIrq | output | 1 | Masked done interrupt |
| srcPtr | output | ADDR_W | Source pointer |
| dstPtr | output | ADDR_W | Destination pointer |
| count | output | CNT_W | Remaining byte count |

## Verification
The bench places a one-clock done pulse inside the read phase with the synchronizer in use, and checks that the paired write still lands before the stop. A design that sampled on the wrong clock would miss the pulse or would drop the write. The same pulse is repeated with the bypass set, where it must be ignored; a design with the synchronizer sense inverted would stop there. A done held during a write phase must stop the channel with the count left part-way. A zero starting count must stop the channel without any request, and a suspend must freeze the count exactly. Errors such as a missing saturation on the last odd-sized operand, or an interrupt flag cleared by a restart, show up as a count, pointer or doneIrq mismatch against the per-clock model.

// File: rtl/dma_term_pkg.sv
package dma_term_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_XFER  = 2'd3
  } chanState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic advSrc;
    logic advDst;
    logic decCnt;
    logic wrSrc;
    logic wrDst;
    logic wrCnt;
  } dpStrobe_t;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;

  function automatic logic [2:0] sizeBytes(input logic [1:0] code);
    if (code[1])      return 3'd4;
    else if (code[0]) return 3'd2;
    else              return 3'd1;
  endfunction

endpackage

// File: rtl/dma_term_dp.sv
module dma_term_dp
  import dma_term_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [1:0]        opSize,
  input  logic [ADDR_W-1:0] wrData,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [CNT_W-1:0]  count,
  output logic              cntIsZero,
  output logic              cntLastOp
);

  localparam int NUM_PTR = 2;

  logic [2:0]        stepBytes;
  logic [CNT_W-1:0]  stepCnt;
  logic [ADDR_W-1:0] ptrQ [NUM_PTR];
  logic [NUM_PTR-1:0] advVec;
  logic [NUM_PTR-1:0] wrVec;

  assign stepBytes = sizeBytes(opSize);
  assign stepCnt   = CNT_W'(stepBytes);
  assign advVec    = {stb.advDst, stb.advSrc};
  assign wrVec     = {stb.wrDst, stb.wrSrc};

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          ptrQ[i] <= '0;
      else if (wrVec[i])  ptrQ[i] <= wrData;
      else if (advVec[i]) ptrQ[i] <= ptrQ[i] + ADDR_W'(stepBytes);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                count <= '0;
    else if (stb.wrCnt)       count <= wrData[CNT_W-1:0];
    else if (stb.decCnt)      count <= cntLastOp ? '0 : count - stepCnt;
  end

  assign srcPtr    = ptrQ[0];
  assign dstPtr    = ptrQ[1];
  assign cntIsZero = (count == '0);
  assign cntLastOp = (count <= stepCnt);

  AST_CNT_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    (stb.decCnt && !cntIsZero) |=> (count < $past(count))); // R4

  AST_LOAD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrCnt |-> !stb.decCnt)); // R13

endmodule

// File: rtl/dma_term_fsm.sv
module dma_term_fsm
  import dma_term_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startSet,
  input  logic       startClr,
  input  logic       dualMode,
  input  logic       devIsDst,
  input  logic       syncBypass,
  input  logic       intClr,
  input  logic       wrEn,
  input  logic [1:0] wrSel,
  input  logic       busRdy,
  input  logic       extDone,
  input  logic       cntIsZero,
  input  logic       cntLastOp,
  output dpStrobe_t  stb,
  output logic       busReq,
  output logic       busWrite,
  output logic       addrUseDst,
  output logic       devAck,
  output logic       startBit,
  output logic       irqFlag
);

  chanState_t state, nextState;
  logic extQ, wrFirst, doneLatch;
  logic doneEff, sampleNow, doneHit, opEnd, term, wrAllowed;

  assign doneEff = syncBypass ? extDone : extQ;

  always_comb begin
    nextState = state;
    stb       = '0;
    sampleNow = 1'b0;
    opEnd     = 1'b0;
    term      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startBit) begin
          if (cntIsZero) term = 1'b1;
          else           nextState = dualMode ? ST_READ : ST_XFER;
        end
      end
      ST_READ: begin
        if (busRdy) begin
          stb.advSrc = 1'b1;
          nextState  = ST_WRITE;
        end
      end
      ST_WRITE: begin
        sampleNow = devIsDst ? busRdy : wrFirst;
        if (busRdy) begin
          stb.advDst = 1'b1;
          stb.decCnt = 1'b1;
          opEnd      = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      ST_XFER: begin
        sampleNow = busRdy;
        if (busRdy) begin
          stb.advSrc = devIsDst;
          stb.advDst = !devIsDst;
          stb.decCnt = 1'b1;
          opEnd      = 1'b1;
          nextState  = ST_IDLE;
        end
      end
    endcase
    doneHit = sampleNow && doneEff;
    if (opEnd) term = cntLastOp || doneLatch || doneHit;
    wrAllowed = wrEn && !startBit && (state == ST_IDLE);
    stb.wrSrc = wrAllowed && (wrSel == SEL_SRC);
    stb.wrDst = wrAllowed && (wrSel == SEL_DST);
    stb.wrCnt = wrAllowed && (wrSel == SEL_CNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      startBit  <= 1'b0;
      irqFlag   <= 1'b0;
      extQ      <= 1'b0;
      wrFirst   <= 1'b0;
      doneLatch <= 1'b0;
    end else begin
      state     <= nextState;
      extQ      <= extDone;
      wrFirst   <= (state == ST_READ) && busRdy;
      doneLatch <= opEnd ? 1'b0 : (doneLatch || doneHit);
      if (term || startClr) startBit <= 1'b0;
      else if (startSet)    startBit <= 1'b1;
      if (term)             irqFlag <= 1'b1;
      else if (intClr)      irqFlag <= 1'b0;
    end
  end

  assign busReq     = (state != ST_IDLE);
  assign busWrite   = (state == ST_WRITE) || ((state == ST_XFER) && !devIsDst);
  assign addrUseDst = (state == ST_WRITE) || ((state == ST_XFER) && !devIsDst);
  assign devAck     = (state == ST_XFER) ||
                      ((state == ST_READ) && !devIsDst) ||
                      ((state == ST_WRITE) && devIsDst);

  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && busRdy) |=> (busReq && busWrite)); // R2

  AST_TERM_HALTS: assert property (@(posedge clk) disable iff (!rstN)
    (opEnd && term) |=> (!startBit && irqFlag && !busReq)); // R9

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !intClr) |=> irqFlag); // R10

  AST_ZERO_NO_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startBit && cntIsZero) |=> !busReq); // R11

  AST_PARKED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !startBit) |=> !busReq); // R12

endmodule

// File: rtl/dma_term_ctl.sv
module dma_term_ctl
  import dma_term_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startSet,
  input  logic              startClr,
  input  logic              dualMode,
  input  logic              devIsDst,
  input  logic              syncBypass,
  input  logic [1:0]        opSize,
  input  logic              intMask,
  input  logic              intClr,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [ADDR_W-1:0] wrData,
  input  logic              busRdy,
  input  logic              extDone,
  output logic              busReq,
  output logic              busWrite,
  output logic [ADDR_W-1:0] busAddr,
  output logic              devAck,
  output logic              active,
  output logic              doneIrq,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [CNT_W-1:0]  count
);

  dpStrobe_t stb;
  logic cntIsZero, cntLastOp, addrUseDst, irqFlag;

  dma_term_fsm u_fsm (
    .clk        (clk),
    .rstN       (rstN),
    .startSet   (startSet),
    .startClr   (startClr),
    .dualMode   (dualMode),
    .devIsDst   (devIsDst),
    .syncBypass (syncBypass),
    .intClr     (intClr),
    .wrEn       (wrEn),
    .wrSel      (wrSel),
    .busRdy     (busRdy),
    .extDone    (extDone),
    .cntIsZero  (cntIsZero),
    .cntLastOp  (cntLastOp),
    .stb        (stb),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .addrUseDst (addrUseDst),
    .devAck     (devAck),
    .startBit   (active),
    .irqFlag    (irqFlag)
  );

  dma_term_dp #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .opSize    (opSize),
    .wrData    (wrData),
    .srcPtr    (srcPtr),
    .dstPtr    (dstPtr),
    .count     (count),
    .cntIsZero (cntIsZero),
    .cntLastOp (cntLastOp)
  );

  assign busAddr = !busReq ? '0 : (addrUseDst ? dstPtr : srcPtr);
  assign doneIrq = irqFlag && intMask;

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busRdy) |=> (busReq && $stable(busAddr))); // R2

endmodule

// File: tb/dma_term_ctl_test.sv
module dma_term_ctl_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startSet = 0, startClr = 0, dualMode = 0, devIsDst = 0, syncBypass = 0;
  logic [1:0] opSize = 0;
  logic intMask = 0, intClr = 0, wrEn = 0;
  logic [1:0] wrSel = 0;
  logic [31:0] wrData = 0;
  logic busRdy = 0, extDone = 0;
  logic busReq, busWrite, devAck, active, doneIrq;
  logic [31:0] busAddr, srcPtr, dstPtr;
  logic [15:0] count;

  int nCmp = 0, nBad = 0;
  bit cmpEn = 0;
  int rdyMode = 0;

  always #4 clk = ~clk; // 125 MHz

  dma_term_ctl uut (.*);

  // behavioural reference model
  int mSt, mCnt, mSz, nSt;
  bit mStart, mFlag, mExtQ, mWrFirst, mLatch, eff, samp, fin, term;
  logic [31:0] mSrc, mDst;

  always @(posedge clk) begin
    if (!rstN) begin
      mSt = 0; mCnt = 0; mStart = 0; mFlag = 0; mExtQ = 0; mWrFirst = 0; mLatch = 0;
      mSrc = 0; mDst = 0;
    end else begin
      eff = syncBypass ? extDone : mExtQ;
      mSz = opSize[1] ? 4 : (opSize[0] ? 2 : 1);
      samp = 0; fin = 0; term = 0; nSt = mSt;
      case (mSt)
        0: if (mStart) begin
             if (mCnt == 0) term = 1; else nSt = dualMode ? 1 : 3;
           end else if (wrEn) begin
             if (wrSel == 0) mSrc = wrData;
             else if (wrSel == 1) mDst = wrData;
             else if (wrSel == 2) mCnt = int'(wrData[15:0]);
           end
        1: if (busRdy) begin mSrc = mSrc + mSz; nSt = 2; end
        2: begin
             samp = devIsDst ? busRdy : mWrFirst;
             if (busRdy) begin mDst = mDst + mSz; fin = 1; nSt = 0; end
           end
        default: begin
             samp = busRdy;
             if (busRdy) begin
               if (devIsDst) mSrc = mSrc + mSz; else mDst = mDst + mSz;
               fin = 1; nSt = 0;
             end
           end
      endcase
      if (fin) begin
        term = (mCnt <= mSz) || mLatch || (samp && eff);
        mCnt = (mCnt > mSz) ? mCnt - mSz : 0;
      end
      mLatch = fin ? 0 : (mLatch || (samp && eff));
      mWrFirst = (mSt == 1) && busRdy;
      if (term || startClr) mStart = 0; else if (startSet) mStart = 1;
      if (term) mFlag = 1; else if (intClr) mFlag = 0;
      mExtQ = extDone;
      mSt = nSt;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (cmpEn) begin
      logic [31:0] eAddr;
      eAddr = (mSt == 1) ? mSrc : (mSt == 2) ? mDst : (mSt == 3) ? (devIsDst ? mSrc : mDst) : 32'd0;
      chk("R2", "busReq", busReq, mSt != 0);
      chk("R3", "busWrite", busWrite, (mSt == 2) || (mSt == 3 && !devIsDst));
      chk("R2", "busAddr", busAddr, eAddr);
      chk("R14", "devAck", devAck, (mSt == 3) || (mSt == 1 && !devIsDst) || (mSt == 2 && devIsDst));
      chk("R12", "active", active, mStart);
      chk("R9", "doneIrq", doneIrq, mFlag && intMask);
      chk("R4", "srcPtr", srcPtr, mSrc);
      chk("R4", "dstPtr", dstPtr, mDst);
      chk("R5", "count", count, mCnt);
    end
  end

  // ready generator
  initial forever begin
    @(posedge clk); #1;
    busRdy = (rdyMode == 0) ? 1'b1 : (($urandom % 3) != 0);
  end

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic wrReg(input logic [1:0] sel, input logic [31:0] d);
    wrEn = 1; wrSel = sel; wrData = d; tick(); wrEn = 0;
  endtask
  task automatic go(); startSet = 1; tick(); startSet = 0; endtask
  task automatic waitStop();
    for (int i = 0; i < 3000; i++) begin
      if (!active && !busReq) break;
      tick();
    end
  endtask
  task automatic setup(input bit dm, input bit dd, input bit sb, input logic [1:0] sz,
                       input logic [31:0] s, input logic [31:0] d, input logic [15:0] c);
    dualMode = dm; devIsDst = dd; syncBypass = sb; opSize = sz;
    wrReg(0, s); wrReg(1, d); wrReg(2, {16'd0, c});
  endtask

  initial begin
    intMask = 1;
    repeat (3) tick();
    rstN = 1;
    tick();
    cmpEn = 1;
    // R1 reset state
    chk("R1", "active", active, 0);
    chk("R1", "busReq", busReq, 0);
    chk("R1", "count", count, 0);
    chk("R1", "srcPtr", srcPtr, 0);
    chk("R1", "doneIrq", doneIrq, 0);

    // R2 R5 dual, 4-byte operands, random waits
    rdyMode = 1;
    setup(1, 1, 1, 2, 32'h1000, 32'h2000, 8);
    go(); waitStop();
    chk("R2", "srcPtr end", srcPtr, 32'h1008);
    chk("R5", "count end", count, 0);
    chk("R9", "doneIrq end", doneIrq, 1);

    // R3 R4 single, memory written, 2-byte operands, odd count saturates
    setup(0, 0, 1, 1, 32'h3000, 32'h3800, 5);
    go(); waitStop();
    chk("R3", "dstPtr single wr", dstPtr, 32'h3806);
    chk("R3", "srcPtr untouched", srcPtr, 32'h3000);
    chk("R4", "count saturate", count, 0);
    // R3 single, memory read
    setup(0, 1, 1, 0, 32'h3100, 32'h3900, 3);
    go(); waitStop();
    chk("R3", "srcPtr single rd", srcPtr, 32'h3103);
    chk("R3", "dstPtr untouched", dstPtr, 32'h3900);

    // R6 single access with done held high
    rdyMode = 0; repeat (2) tick();
    setup(0, 0, 1, 0, 32'h0, 32'h6000, 10);
    go(); extDone = 1; waitStop(); extDone = 0;
    chk("R6", "count single done", count, 9);

    // R6 R14 dual, done on destination write
    setup(1, 1, 1, 0, 32'h7000, 32'h7800, 40);
    go();
    for (int i = 0; i < 20; i++) begin
      if (devAck && busWrite) break;
      tick();
    end
    chk("R14", "devAck on write", devAck, 1);
    extDone = 1; tick(); extDone = 0;
    waitStop();
    chk("R6", "count dst done", count, 39);
    chk("R6", "dstPtr dst done", dstPtr, 32'h7801);

    // R7 R8 source done pulse during read, synchronizer in use
    setup(1, 0, 0, 0, 32'h8000, 32'h8800, 40);
    go(); tick(); extDone = 1; tick(); extDone = 0;
    waitStop();
    chk("R7", "write kept dstPtr", dstPtr, 32'h8801);
    chk("R8", "count sync stop", count, 39);
    // R8 same pulse with bypass: not recognised
    setup(1, 0, 1, 0, 32'h8000, 32'h8800, 40);
    go(); tick(); extDone = 1; tick(); extDone = 0;
    waitStop();
    chk("R8", "count bypass run", count, 0);
    chk("R8", "dstPtr bypass run", dstPtr, 32'h8828);

    // R12 R13 suspend, ignored write, resume
    setup(1, 1, 1, 0, 32'h4000, 32'h5000, 20);
    go(); repeat (3) tick();
    wrReg(0, 32'hDEAD0000);
    repeat (3) tick();
    startClr = 1; tick(); startClr = 0;
    repeat (4) tick();
    chk("R12", "parked active", active, 0);
    chk("R12", "parked busReq", busReq, 0);
    begin
      int c1;
      c1 = count;
      chk("R12", "count mid", (c1 > 0 && c1 < 20), 1);
      repeat (6) tick();
      chk("R12", "count frozen", count, c1);
    end
    go(); waitStop();
    chk("R12", "count resumed", count, 0);
    chk("R13", "srcPtr kept", srcPtr, 32'h4014);
    chk("R12", "dstPtr resumed", dstPtr, 32'h5014);

    // R9 R10 flag masking and stickiness
    intMask = 0; tick();
    chk("R9", "masked irq", doneIrq, 0);
    intMask = 1; tick();
    chk("R9", "unmasked irq", doneIrq, 1);
    setup(1, 1, 1, 0, 32'h100, 32'h200, 6);
    go(); tick();
    chk("R10", "flag kept on restart", doneIrq, 1);
    waitStop();
    intClr = 1; tick(); intClr = 0;
    chk("R10", "flag cleared", doneIrq, 0);

    // R11 zero count start
    setup(1, 1, 1, 0, 32'h100, 32'h200, 0);
    go();
    begin
      int seenReq;
      seenReq = 0;
      for (int i = 0; i < 4; i++) begin
        if (busReq) seenReq++;
        tick();
      end
      chk("R11", "no access", seenReq, 0);
    end
    chk("R11", "stopped", active, 0);
    chk("R11", "irq raised", doneIrq, 1);

    repeat (3) tick();
    cmpEn = 0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule